// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block keeps the exception part of a floating-point status register. Each arithmetic operation reports its five IEEE exception flags with a valid strobe. The unit ORs them into a pending-flag register and then into the current-exception field of the status word. A trap-enable field in the same word decides what happens next. If any flag now set in the current-exception field has its enable bit set, the unit raises a one-cycle trap pulse and writes the IEEE-exception code into the trap-type field. If no enabled flag is set, it ORs the current-exception field into the accrued-exception field, which is sticky.

Software can also load the whole status word. A load takes the loadable bits from the new data and keeps the protected bits (trap type and a reserved field) from the old value. The unit decodes the two-bit rounding-mode field into a registered mode code for the arithmetic units. That code follows every change of the status word, loads included. The pending-flag register is cleared by a separate strobe at the start of each new operation.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset, `status_q` is all zeros, `trap_pulse` is 0 and `rnd_mode` is 2'b01 (round to nearest even).
- R2: A flag strobe sets current-exception bits at positions 4:0, with flag bit 4 = invalid, 3 = overflow, 2 = underflow, 1 = divide-by-zero and 0 = inexact. The new bits are visible in `status_q` one cycle after the strobe.
- R3: If the merged flags (pending register plus `flag_in`) are all zero, a flag strobe changes nothing and raises no trap. With no strobe and no load, `status_q` holds.
- R4: The trap-enable field is bits 27:23, aligned bit for bit with the current-exception field. If the AND of the updated current-exception field with this field is nonzero, `trap_pulse` is 1 in the following cycle and the trap-type field, bits 16:14, becomes 3'b001. The accrued field is left unchanged.
- R5: If no enabled exception is present, the updated current-exception field is ORed into the accrued field, bits 9:5. Only a load clears accrued bits.
- R6: The pending register collects flags across strobes until `clr_pend` is asserted. When `clr_pend` and `flag_vld` arrive in the same cycle, the register is cleared first and then takes `flag_in`.
- R7: Rounding-mode field bits 31:30 decode to `rnd_mode` as follows: 00 gives nearest-even (2'b01), 01 gives toward zero (2'b00), 10 gives toward +infinity (2'b11) and 11 gives toward -infinity (2'b10). Any other encoding gives toward zero.
- R8: A load writes `(ld_data & LOAD_MASK) | (status_q & ~LOAD_MASK)`, with default mask 32'hFFF03FFF, so bits 19:14 are kept. `rnd_mode` follows the loaded value in the same cycle that `status_q` does.
- R9: If a load and a flag strobe arrive in the same cycle, the load alone sets `status_q` and no trap is raised. The flags still enter the pending register.
- R10: `trap_pulse` is high only in the cycle right after a flag strobe that trapped. It is low in the next cycle unless another strobe traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_vld | input | 1 | Exception flags valid strobe |
| flag_in | input | 5 | IEEE flags {invalid, overflow, underflow, div-by-zero, inexact} |
| clr_pend | input | 1 | Clear the pending-flag register |
| ld_vld | input | 1 | Status-word load strobe |
| ld_data | input | 32 | New status-word value |
| status_q | output | 32 | Status word |
| rnd_mode | output | 2 | Decoded rounding mode for the arithmetic units |
| trap_pulse | output | 1 | One-cycle floating-point trap request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, current flags at 4:0, accrued flags at 9:5, enables at 27:23, trap type at 16:14, rounding mode at 31:30 and load mask 32'hFFF03FFF. With these values every field position and the protected-bit mask can be checked against fixed expected words. Each flag reaches its own current-exception and accrued bits, a trap leaves the protected trap-type bit behind through later loads, and all four rounding encodings can be driven through the load port. The pending register is observed by first clearing the status word with a load and then sending an all-zero strobe.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    typedef enum logic [1:0] {
        RND_ZERO = 2'b00,
        RND_NEAR = 2'b01,
        RND_DOWN = 2'b10,
        RND_UP   = 2'b11
    } rnd_e;

    localparam logic [2:0] TRAP_KIND_IEEE = 3'b001;
endpackage

// File: rtl/fpx_rnd_decode.sv
module fpx_rnd_decode
    import fpx_pkg::*;
(
    input  logic [1:0] rm_field,
    output rnd_e       mode
);
    always_comb begin
        unique case (rm_field)
            2'b00:   mode = RND_NEAR;
            2'b01:   mode = RND_ZERO;
            2'b10:   mode = RND_UP;
            2'b11:   mode = RND_DOWN;
            default: mode = RND_ZERO;
        endcase
    end
endmodule

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval #(
    parameter int NFLAG = 5
) (
    input  logic [NFLAG-1:0] cur_old,
    input  logic [NFLAG-1:0] eff_flags,
    input  logic [NFLAG-1:0] enables,
    input  logic [NFLAG-1:0] acc_old,
    output logic [NFLAG-1:0] cur_new,
    output logic [NFLAG-1:0] acc_new,
    output logic             take_trap
);
    logic [NFLAG-1:0] hit;

    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        assign cur_new[i] = cur_old[i] | eff_flags[i];
        assign hit[i]     = cur_new[i] & enables[i];
    end

    assign take_trap = |hit;
    assign acc_new   = take_trap ? acc_old : (acc_old | cur_new);
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
#(
    parameter int               STAT_W    = 32,
    parameter int               NFLAG     = 5,
    parameter int               CUR_LSB   = 0,
    parameter int               ACC_LSB   = 5,
    parameter int               TEM_LSB   = 23,
    parameter int               KIND_LSB  = 14,
    parameter int               RM_LSB    = 30,
    parameter logic [STAT_W-1:0] LOAD_MASK = 32'hFFF0_3FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_vld,
    input  logic [NFLAG-1:0]  flag_in,
    input  logic              clr_pend,
    input  logic              ld_vld,
    input  logic [STAT_W-1:0] ld_data,
    output logic [STAT_W-1:0] status_q,
    output logic [1:0]        rnd_mode,
    output logic              trap_pulse
);
    localparam int KIND_W = $bits(TRAP_KIND_IEEE);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [NFLAG-1:0]  pend;
        rnd_e              rnd;
        logic              trap;
    } state_t;

    state_t st_d, st_q;

    logic [NFLAG-1:0] pend_base, eff_flags;
    logic [NFLAG-1:0] cur_new, acc_new;
    logic             take_trap;
    logic [STAT_W-1:0] merged_ld;
    rnd_e             rnd_next;

    assign pend_base = clr_pend ? '0 : st_q.pend;
    assign eff_flags = pend_base | (flag_vld ? flag_in : '0);
    assign merged_ld = (ld_data & LOAD_MASK) | (st_q.status & ~LOAD_MASK);

    fpx_trap_eval #(.NFLAG(NFLAG)) u_eval (
        .cur_old   (st_q.status[CUR_LSB +: NFLAG]),
        .eff_flags (eff_flags),
        .enables   (st_q.status[TEM_LSB +: NFLAG]),
        .acc_old   (st_q.status[ACC_LSB +: NFLAG]),
        .cur_new   (cur_new),
        .acc_new   (acc_new),
        .take_trap (take_trap)
    );

    fpx_rnd_decode u_rnd (
        .rm_field (st_d.status[RM_LSB +: 2]),
        .mode     (rnd_next)
    );

    always_comb begin
        st_d        = st_q;
        st_d.pend   = eff_flags;
        st_d.trap   = 1'b0;
        if (ld_vld) begin
            st_d.status = merged_ld;
        end else if (flag_vld && (|eff_flags)) begin
            st_d.status[CUR_LSB +: NFLAG] = cur_new;
            if (take_trap) begin
                st_d.status[KIND_LSB +: KIND_W] = TRAP_KIND_IEEE;
                st_d.trap                       = 1'b1;
            end else begin
                st_d.status[ACC_LSB +: NFLAG] = acc_new;
            end
        end
        st_d.rnd = rnd_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{status: '0, pend: '0, rnd: RND_NEAR, trap: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q   = st_q.status;
    assign rnd_mode   = st_q.rnd;
    assign trap_pulse = st_q.trap;
endmodule

// File: rtl/fpx_status_unit_chk.sv
module fpx_status_unit_chk #(
    parameter int               STAT_W    = 32,
    parameter int               NFLAG     = 5,
    parameter int               ACC_LSB   = 5,
    parameter int               KIND_LSB  = 14,
    parameter int               RM_LSB    = 30,
    parameter logic [STAT_W-1:0] LOAD_MASK = 32'hFFF0_3FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag_vld,
    input logic              ld_vld,
    input logic [STAT_W-1:0] ld_data,
    input logic [STAT_W-1:0] status_q,
    input logic [1:0]        rnd_mode,
    input logic              trap_pulse
);
    function automatic logic [1:0] rm_expect(input logic [1:0] f);
        case (f)
            2'b00:   return 2'b01;
            2'b01:   return 2'b00;
            2'b10:   return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_vld && !ld_vld) |=> $stable(status_q));

    assert_trap_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (status_q[KIND_LSB +: 3] == 3'b001));

    assert_acc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_vld |=> ((status_q[ACC_LSB +: NFLAG] & $past(status_q[ACC_LSB +: NFLAG]))
                     == $past(status_q[ACC_LSB +: NFLAG])));

    assert_rnd_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_mode == rm_expect(status_q[RM_LSB +: 2]));

    assert_load_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld |=> (((status_q & LOAD_MASK) == ($past(ld_data) & LOAD_MASK)) &&
                    ((status_q & ~LOAD_MASK) == ($past(status_q) & ~LOAD_MASK))));

    assert_trap_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> $past(flag_vld && !ld_vld));
endmodule

bind fpx_status_unit fpx_status_unit_chk #(
    .STAT_W(STAT_W), .NFLAG(NFLAG), .ACC_LSB(ACC_LSB),
    .KIND_LSB(KIND_LSB), .RM_LSB(RM_LSB), .LOAD_MASK(LOAD_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flag_vld(flag_vld), .ld_vld(ld_vld),
    .ld_data(ld_data), .status_q(status_q), .rnd_mode(rnd_mode),
    .trap_pulse(trap_pulse)
);

// File: tb/fpx_status_unit_tb.sv
`timescale 1ns/1ps
module fpx_status_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_vld = 1'b0;
    logic [4:0]  flag_in = '0;
    logic        clr_pend = 1'b0;
    logic        ld_vld = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] status_q;
    logic [1:0]  rnd_mode;
    logic        trap_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    fpx_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .flag_vld(flag_vld), .flag_in(flag_in),
        .clr_pend(clr_pend), .ld_vld(ld_vld), .ld_data(ld_data),
        .status_q(status_q), .rnd_mode(rnd_mode), .trap_pulse(trap_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit ld, input logic [31:0] d, input bit fv,
                       input logic [4:0] f, input bit clr);
        ld_vld = ld; ld_data = d; flag_vld = fv; flag_in = f; clr_pend = clr;
        @(negedge clk);
        ld_vld = 0; ld_data = '0; flag_vld = 0; flag_in = '0; clr_pend = 0;
    endtask

    task automatic t_reset;
        chk("R1 status", status_q, 32'h0);
        chk("R1 trap", {31'b0, trap_pulse}, 32'h0);
        chk("R1 rnd", {30'b0, rnd_mode}, 32'h1);
    endtask

    task automatic t_each_flag;
        for (int i = 0; i < 5; i++) begin
            cyc(1, 32'h0, 0, 5'h0, 0);
            cyc(0, 32'h0, 1, 5'(1 << i), 1);
            chk("R2/R5 single flag", status_q, (32'h1 << i) | (32'h1 << (i + 5)));
            chk("R2 no trap", {31'b0, trap_pulse}, 32'h0);
        end
    endtask

    task automatic t_quiet;
        cyc(1, 32'h0, 0, 5'h0, 0);
        cyc(0, 32'h0, 1, 5'h0, 1);
        chk("R3 empty strobe", status_q, 32'h0);
        chk("R3 no trap", {31'b0, trap_pulse}, 32'h0);
        cyc(0, 32'h0, 0, 5'h0, 0);
        chk("R3 hold", status_q, 32'h0);
    endtask

    task automatic t_trap;
        // enable invalid only, raise inexact: accumulate
        cyc(1, 32'h1 << 27, 0, 5'h0, 0);
        cyc(0, 32'h0, 1, 5'h01, 1);
        chk("R5 masked accumulate", status_q, (32'h1 << 27) | 32'h21);
        chk("R5 no trap", {31'b0, trap_pulse}, 32'h0);
        // enable overflow, raise overflow: trap
        cyc(1, 32'h1 << 26, 0, 5'h0, 0);
        cyc(0, 32'h0, 1, 5'h08, 1);
        chk("R4 trap word", status_q, 32'h0400_4008);
        chk("R4 trap pulse", {31'b0, trap_pulse}, 32'h1);
        cyc(0, 32'h0, 0, 5'h0, 0);
        chk("R10 pulse ends", {31'b0, trap_pulse}, 32'h0);
    endtask

    task automatic t_pending;
        cyc(1, 32'h0, 0, 5'h0, 0);
        cyc(0, 32'h0, 1, 5'h01, 1);
        cyc(1, 32'h0, 0, 5'h0, 0);
        chk("R8 protected kept", status_q, 32'h0000_4000);
        cyc(0, 32'h0, 1, 5'h0, 0);
        chk("R6 pending replayed", status_q, 32'h0000_4021);
        cyc(1, 32'h0, 0, 5'h0, 0);
        cyc(0, 32'h0, 1, 5'h0, 1);
        chk("R6 pending cleared", status_q, 32'h0000_4000);
    endtask

    task automatic t_rounding;
        logic [1:0] exp_m [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
        for (int m = 0; m < 4; m++) begin
            cyc(1, 32'(m) << 30, 0, 5'h0, 0);
            chk("R7 rnd decode", {30'b0, rnd_mode}, {30'b0, exp_m[m]});
        end
    endtask

    task automatic t_load;
        cyc(1, 32'hFFFF_FFFF, 0, 5'h0, 0);
        chk("R8 masked load", status_q, 32'hFFF0_7FFF);
        chk("R8 rnd follows", {30'b0, rnd_mode}, 32'h2);
        cyc(1, 32'h0, 0, 5'h0, 0);
        chk("R8 reload", status_q, 32'h0000_4000);
    endtask

    task automatic t_collide;
        cyc(1, 32'h0, 1, 5'h1F, 1);
        chk("R9 load wins", status_q, 32'h0000_4000);
        chk("R9 no trap", {31'b0, trap_pulse}, 32'h0);
        cyc(0, 32'h0, 1, 5'h0, 0);
        chk("R9 flags kept pending", status_q, 32'h0000_43FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_each_flag();
        t_quiet();
        t_trap();
        t_pending();
        t_rounding();
        t_load();
        t_collide();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule